// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Sequencer

This block drives a single-port synchronous RAM through a March algorithm chosen at start time. A March algorithm is an ordered list of elements. Each element sweeps every address in one direction, and at each address it performs a short, fixed list of reads and writes using solid-zero or solid-one words. Every read has an expected value, which is the last value the algorithm wrote to that cell. The sequencer compares the returned word against that value one cycle after it issues the read.

The caller selects an algorithm, pulses `start` and waits for the one-cycle `done` pulse. When `done` arrives, `fail` shows whether any read differed from its expectation. If one did, `fail_addr` and `fail_elem` give the address and the element index of the first mismatch. A parameter chooses whether the test stops at the first mismatch or sweeps to the end.

Top module: `march_seq`

## Requirements
- R1: After reset, `done`, `fail` and `ram_we` are 0. `start` is accepted only while the sequencer is idle, and a `start` pulse during a running test does not change the running test or its length.
- R2: `alg_sel` encoding (index 0 is the first element, "up" is address 0 to DEPTH-1 and "down" is the reverse):
  - 0: MATS {up w0; up r0,w1; up r1}
  - 1: MATS+ {up w0; up r0,w1; down r1,w0}
  - 2: MATS++ {up w0; up r0,w1; down r1,w0,r0}
  - 3: March X {up w0; up r0,w1; down r1,w0; up r0}
  - 4: March C- {up w0; up r0,w1; up r1,w0; down r0,w1; down r1,w0; up r0}
  - 5: March Y {up w0; up r0,w1,r1; down r1,w0,r0; up r0}
  - 6 and 7 run MATS.
- R3: With no mismatch, `done` is high for exactly one cycle. This is the cycle that follows k*DEPTH+1 rising edges after the edge that samples `start`, where k is 4, 5, 6, 6, 10 and 8 for codes 0 to 5.
- R4: One operation is issued per cycle. All operations of an element complete at an address before the address moves on. The first operation after `start` writes an all-zero word to address 0.
- R5: A w0 or w1 drives `ram_we`=1 with `ram_wdata` all zeros or all ones. A read drives `ram_we`=0, and its expected word is all zeros for r0 and all ones for r1.
- R6: `ram_rdata` is compared in the cycle after the read is issued, which matches one cycle of RAM read latency.
- R7: At the first mismatch, `fail` rises and `fail_addr`/`fail_elem` capture the address and the element index of that read. Later mismatches do not change them.
- R8: With STOP_ON_FAIL=1, `done` pulses in the cycle following two edges after the edge that ends the comparison cycle of the first mismatch. In cycles counted from the `start` edge, this is p+3 for the operation with zero-based index p. With STOP_ON_FAIL=0, the full length of R3 is kept.
- R9: `fail`, `fail_addr` and `fail_elem` hold until the next accepted `start`, which clears `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a test (accepted only when idle) |
| alg_sel | input | 3 | Algorithm code, see R2 |
| ram_addr | output | AW | RAM address |
| ram_we | output | 1 | RAM write enable (read when low) |
| ram_wdata | output | WIDTH | RAM write data |
| ram_rdata | input | WIDTH | RAM read data, one cycle after the read |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |

## Verification
Several properties are checked on every cycle: `done` never lasts two cycles, the address only moves by one step in the element's direction, and the element and address hold while operations remain at an address. The checks also confirm that the failure record is sticky and frozen after its first capture, and that a mismatch in stop mode ends the sweep. Other behaviours can only be shown by the bench's scenarios, because they need a RAM model with injected stuck cells and aliased addresses. These include that each algorithm has the correct total length, that the down elements reach the stuck cell in the right order, that the captured address and element are correct, and that a mid-test `start` is ignored.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int ALG_W     = 3;
  localparam int MAX_OPS   = 3;
  localparam int MAX_ELEMS = 6;
  localparam int ELEM_W    = $clog2(MAX_ELEMS);
  localparam int OPI_W     = $clog2(MAX_OPS + 1);

  // bit 1: write, bit 0: data value (write data or expected read value)
  typedef enum logic [1:0] {
    OP_R0 = 2'b00,
    OP_R1 = 2'b01,
    OP_W0 = 2'b10,
    OP_W1 = 2'b11
  } mop_e;

  localparam logic UP = 1'b0;
  localparam logic DN = 1'b1;

  typedef struct packed {
    logic                      down;
    logic [OPI_W-1:0]          last;
    logic [MAX_OPS-1:0][1:0]   ops;
  } melem_t;

  function automatic melem_t mk_elem(input logic dir, input mop_e o0, input mop_e o1,
                                     input mop_e o2, input int nops);
    melem_t e;
    e.down   = dir;
    e.last   = OPI_W'(nops - 1);
    e.ops[0] = o0;
    e.ops[1] = o1;
    e.ops[2] = o2;
    return e;
  endfunction

  function automatic logic [ALG_W-1:0] fix_alg(input logic [ALG_W-1:0] s);
    return (s > ALG_W'(5)) ? '0 : s;
  endfunction

  function automatic logic [ELEM_W-1:0] final_elem(input logic [ALG_W-1:0] alg);
    case (alg)
      3'd3, 3'd5: return ELEM_W'(3);
      3'd4:       return ELEM_W'(5);
      default:    return ELEM_W'(2);
    endcase
  endfunction

  function automatic melem_t elem_of(input logic [ALG_W-1:0] alg, input logic [ELEM_W-1:0] idx);
    melem_t e;
    e = mk_elem(UP, OP_W0, OP_R0, OP_R0, 1);
    if (idx != '0) begin
      case (alg)
        3'd1: if (idx == 3'd1) e = mk_elem(UP, OP_R0, OP_W1, OP_R0, 2);
              else             e = mk_elem(DN, OP_R1, OP_W0, OP_R0, 2);
        3'd2: if (idx == 3'd1) e = mk_elem(UP, OP_R0, OP_W1, OP_R0, 2);
              else             e = mk_elem(DN, OP_R1, OP_W0, OP_R0, 3);
        3'd3: case (idx)
                3'd1:    e = mk_elem(UP, OP_R0, OP_W1, OP_R0, 2);
                3'd2:    e = mk_elem(DN, OP_R1, OP_W0, OP_R0, 2);
                default: e = mk_elem(UP, OP_R0, OP_R0, OP_R0, 1);
              endcase
        3'd4: case (idx)
                3'd1:    e = mk_elem(UP, OP_R0, OP_W1, OP_R0, 2);
                3'd2:    e = mk_elem(UP, OP_R1, OP_W0, OP_R0, 2);
                3'd3:    e = mk_elem(DN, OP_R0, OP_W1, OP_R0, 2);
                3'd4:    e = mk_elem(DN, OP_R1, OP_W0, OP_R0, 2);
                default: e = mk_elem(UP, OP_R0, OP_R0, OP_R0, 1);
              endcase
        3'd5: case (idx)
                3'd1:    e = mk_elem(UP, OP_R0, OP_W1, OP_R1, 3);
                3'd2:    e = mk_elem(DN, OP_R1, OP_W0, OP_R0, 3);
                default: e = mk_elem(UP, OP_R0, OP_R0, OP_R0, 1);
              endcase
        default: if (idx == 3'd1) e = mk_elem(UP, OP_R0, OP_W1, OP_R0, 2);
                 else             e = mk_elem(UP, OP_R1, OP_R0, OP_R0, 1);
      endcase
    end
    return e;
  endfunction

  function automatic logic dir_of(input logic [ALG_W-1:0] alg, input logic [ELEM_W-1:0] idx);
    melem_t e;
    e = elem_of(alg, idx);
    return e.down;
  endfunction
endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_down,
  input  logic          step,
  input  logic          step_down,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load | step;
    addr_d  = addr_q;
    if (load)      addr_d = load_down ? TOP : '0;
    else if (step) addr_d = step_down ? addr_q - 1'b1 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr   = addr_q;
  assign at_end = step_down ? (addr_q == '0) : (addr_q == TOP);

  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n) addr_q <= TOP)
    else $error("address outside array");
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !step_down) |=> addr_q == $past(addr_q) + 1'b1)
    else $error("ascending step wrong");
  p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && step_down) |=> addr_q == $past(addr_q) - 1'b1)
    else $error("descending step wrong");
endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int WIDTH = 8,
  parameter int AW    = 4,
  parameter int EW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             chk,
  input  logic             exp_bit,
  input  logic [AW-1:0]    chk_addr,
  input  logic [EW-1:0]    chk_elem,
  input  logic [WIDTH-1:0] rdata,
  output logic             mismatch,
  output logic             fail,
  output logic [AW-1:0]    fail_addr,
  output logic [EW-1:0]    fail_elem
);
  logic          pend_q, exp_q;
  logic [AW-1:0] paddr_q, faddr_q;
  logic [EW-1:0] pelem_q, felem_q;
  logic          fail_q, capture;

  // read issued in cycle t, data compared in cycle t+1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      exp_q   <= 1'b0;
      paddr_q <= '0;
      pelem_q <= '0;
    end else begin
      pend_q <= chk;
      if (chk) begin
        exp_q   <= exp_bit;
        paddr_q <= chk_addr;
        pelem_q <= chk_elem;
      end
    end
  end

  always_comb begin
    mismatch = pend_q && (rdata != {WIDTH{exp_q}});
    capture  = mismatch && !fail_q && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      felem_q <= '0;
    end else if (clr) begin
      fail_q  <= 1'b0;
    end else if (capture) begin
      fail_q  <= 1'b1;
      faddr_q <= paddr_q;
      felem_q <= pelem_q;
    end
  end

  assign fail      = fail_q;
  assign fail_addr = faddr_q;
  assign fail_elem = felem_q;

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr) |=> fail_q)
    else $error("fail dropped without start");
  p_info_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr) |=> ($stable(faddr_q) && $stable(felem_q)))
    else $error("failure record overwritten");
  p_first_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !fail_q && !clr) |=> (fail_q && faddr_q == $past(paddr_q)))
    else $error("first mismatch not captured");
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int WIDTH        = 8,
  parameter bit STOP_ON_FAIL = 1'b1,
  parameter int AW           = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ALG_W-1:0]  alg_sel,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_we,
  output logic [WIDTH-1:0]  ram_wdata,
  input  logic [WIDTH-1:0]  ram_rdata,
  output logic              done,
  output logic              fail,
  output logic [AW-1:0]     fail_addr,
  output logic [ELEM_W-1:0] fail_elem
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_e;

  st_e              st_q, st_d;
  logic [ALG_W-1:0]  alg_q, alg_d;
  logic [ELEM_W-1:0] elem_q, elem_d, elem_inc;
  logic [OPI_W-1:0]  opi_q, opi_d;
  logic              done_q, seq_en;
  melem_t            cur;
  logic [1:0]        op;
  logic              is_run, last_op, last_elem, abort, mismatch;
  logic              ag_load, ag_load_down, ag_step, ag_at_end;
  logic [AW-1:0]     addr;

  assign elem_inc  = elem_q + 1'b1;
  assign cur       = elem_of(alg_q, elem_q);
  assign op        = cur.ops[opi_q];
  assign is_run    = (st_q == S_RUN);
  assign last_op   = (opi_q == cur.last);
  assign last_elem = (elem_q == final_elem(alg_q));
  assign abort     = STOP_ON_FAIL && mismatch;
  assign seq_en    = (st_q != S_IDLE) || start;

  always_comb begin
    st_d         = st_q;
    alg_d        = alg_q;
    elem_d       = elem_q;
    opi_d        = opi_q;
    ag_load      = 1'b0;
    ag_load_down = 1'b0;
    ag_step      = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        st_d         = S_RUN;
        alg_d        = fix_alg(alg_sel);
        elem_d       = '0;
        opi_d        = '0;
        ag_load      = 1'b1;
        ag_load_down = dir_of(fix_alg(alg_sel), '0);
      end
      S_RUN: begin
        if (abort) begin
          st_d = S_DRAIN;
        end else if (!last_op) begin
          opi_d = opi_q + 1'b1;
        end else begin
          opi_d = '0;
          if (!ag_at_end) begin
            ag_step = 1'b1;
          end else if (last_elem) begin
            st_d = S_DRAIN;
          end else begin
            elem_d       = elem_inc;
            ag_load      = 1'b1;
            ag_load_down = dir_of(alg_q, elem_inc);
          end
        end
      end
      S_DRAIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      alg_q  <= '0;
      elem_q <= '0;
      opi_q  <= '0;
    end else if (seq_en) begin
      st_q   <= st_d;
      alg_q  <= alg_d;
      elem_q <= elem_d;
      opi_q  <= opi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (st_q == S_DRAIN);
  end

  march_addr_gen #(.DEPTH(DEPTH), .AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ag_load),
    .load_down (ag_load_down),
    .step      (ag_step),
    .step_down (cur.down),
    .addr      (addr),
    .at_end    (ag_at_end)
  );

  march_cmp #(.WIDTH(WIDTH), .AW(AW), .EW(ELEM_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (st_q == S_IDLE && start),
    .chk       (is_run && !op[1]),
    .exp_bit   (op[0]),
    .chk_addr  (addr),
    .chk_elem  (elem_q),
    .rdata     (ram_rdata),
    .mismatch  (mismatch),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem)
  );

  assign ram_addr  = addr;
  assign ram_we    = is_run && op[1];
  assign ram_wdata = {WIDTH{op[0]}};
  assign done      = done_q;

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q)
    else $error("done longer than one cycle");
  p_elem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_run && !last_op) |=> ($stable(elem_q) && $stable(addr)))
    else $error("address moved before element operations finished");

  generate
    if (STOP_ON_FAIL) begin : g_stop
      p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_run && mismatch) |=> (st_q == S_DRAIN))
        else $error("mismatch did not end the test");
    end
  endgenerate
endmodule

// File: tb/tb_march_seq.sv
`timescale 1ns/1ps
module tb_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [1:0]       fmode,
  input  logic [AW-1:0]    fa,
  input  logic [AW-1:0]    fa2
);
  // fmode: 0 good, 1 bit0 of cell fa stuck at 0, 2 stuck at 1, 3 address fa decodes to fa2
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    eff;
  logic [WIDTH-1:0] rd;
  always_comb begin
    eff = (fmode == 2'd3 && addr == fa) ? fa2 : addr;
    rd  = mem[eff];
    if (eff == fa && fmode == 2'd1) rd[0] = 1'b0;
    if (eff == fa && fmode == 2'd2) rd[0] = 1'b1;
  end
  always_ff @(posedge clk) begin
    if (we) mem[eff] <= wdata;
    else    rdata    <= rd;
  end
endmodule

module tb_march_seq;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int AW    = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, start;
  logic [2:0]       alg_sel;
  logic [1:0]       fmode;
  logic [AW-1:0]    fa, fa2;
  logic [AW-1:0]    ram_addr, ram_addr_c, fail_addr, fail_addr_c;
  logic             ram_we, ram_we_c, done, done_c, fail, fail_c;
  logic [WIDTH-1:0] ram_wdata, ram_wdata_c, ram_rdata, ram_rdata_c;
  logic [2:0]       fail_elem, fail_elem_c;

  march_seq #(.DEPTH(DEPTH), .WIDTH(WIDTH), .STOP_ON_FAIL(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .done(done), .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem));
  tb_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram (
    .clk(clk), .addr(ram_addr), .we(ram_we), .wdata(ram_wdata), .rdata(ram_rdata),
    .fmode(fmode), .fa(fa), .fa2(fa2));

  march_seq #(.DEPTH(DEPTH), .WIDTH(WIDTH), .STOP_ON_FAIL(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
    .ram_addr(ram_addr_c), .ram_we(ram_we_c), .ram_wdata(ram_wdata_c), .ram_rdata(ram_rdata_c),
    .done(done_c), .fail(fail_c), .fail_addr(fail_addr_c), .fail_elem(fail_elem_c));
  tb_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram_c (
    .clk(clk), .addr(ram_addr_c), .we(ram_we_c), .wdata(ram_wdata_c), .rdata(ram_rdata_c),
    .fmode(fmode), .fa(fa), .fa2(fa2));

  typedef struct packed {
    logic [2:0]  sel;
    logic [1:0]  fm;
    logic [3:0]  fa;
    logic [3:0]  fa2;
    logic [15:0] n_stop;
    logic [15:0] n_cont;
    logic        f;
    logic [3:0]  faddr;
    logic [2:0]  felem;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 4'd0,  4'd0, 16'd65,  16'd65,  1'b0, 4'd0,  3'd0},
    '{3'd1, 2'd0, 4'd0,  4'd0, 16'd81,  16'd81,  1'b0, 4'd0,  3'd0},
    '{3'd2, 2'd0, 4'd0,  4'd0, 16'd97,  16'd97,  1'b0, 4'd0,  3'd0},
    '{3'd3, 2'd0, 4'd0,  4'd0, 16'd97,  16'd97,  1'b0, 4'd0,  3'd0},
    '{3'd4, 2'd0, 4'd0,  4'd0, 16'd161, 16'd161, 1'b0, 4'd0,  3'd0},
    '{3'd5, 2'd0, 4'd0,  4'd0, 16'd129, 16'd129, 1'b0, 4'd0,  3'd0},
    '{3'd1, 2'd2, 4'd3,  4'd0, 16'd25,  16'd81,  1'b1, 4'd3,  3'd1},
    '{3'd4, 2'd1, 4'd12, 4'd0, 16'd75,  16'd161, 1'b1, 4'd12, 3'd2},
    '{3'd1, 2'd1, 4'd12, 4'd0, 16'd57,  16'd81,  1'b1, 4'd12, 3'd2},
    '{3'd5, 2'd1, 4'd7,  4'd0, 16'd42,  16'd129, 1'b1, 4'd7,  3'd1},
    '{3'd1, 2'd3, 4'd5,  4'd9, 16'd37,  16'd81,  1'b1, 4'd9,  3'd1},
    '{3'd0, 2'd1, 4'd0,  4'd0, 16'd51,  16'd65,  1'b1, 4'd0,  3'd2},
    '{3'd3, 2'd2, 4'd15, 4'd0, 16'd49,  16'd97,  1'b1, 4'd15, 3'd1},
    '{3'd6, 2'd0, 4'd0,  4'd0, 16'd65,  16'd65,  1'b0, 4'd0,  3'd0},
    '{3'd7, 2'd2, 4'd1,  4'd0, 16'd21,  16'd65,  1'b1, 4'd1,  3'd1}
  };

  int  nchk = 0;
  int  nfail = 0;
  bit  finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // start sampled at edge E0; counts are edges after E0 until done seen
  task automatic run(input logic [2:0] s, input logic [1:0] fm, input logic [3:0] a,
                     input logic [3:0] a2, input bit poke, output int ns, output int nc);
    int  n;
    bit  bad_wd;
    alg_sel = s; fmode = fm; fa = a; fa2 = a2;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R4 first op is a write", int'(ram_we), 1);
    check("R4 first op address 0", int'(ram_addr), 0);
    check("R4 first op writes zeros", int'(ram_wdata), 0);
    check("R9 fail cleared by start", int'(fail), 0);
    ns = 0; nc = 0; n = 0; bad_wd = 0;
    while ((ns == 0 || nc == 0) && n < 2000) begin
      if (ram_we && ram_wdata != '0 && ram_wdata != '1) bad_wd = 1;
      @(posedge clk); #1;
      n++;
      start = (poke && n == 20);
      if (done && ns == 0)   ns = n;
      if (done_c && nc == 0) nc = n;
    end
    start = 1'b0;
    check("R5 solid write data", int'(bad_wd), 0);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int ns, nc;
    rst_n = 1'b0; start = 1'b0; alg_sel = '0; fmode = '0; fa = '0; fa2 = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset done", int'(done), 0);
    check("R1 reset fail", int'(fail), 0);
    check("R1 reset we", int'(ram_we), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 idle we", int'(ram_we), 0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].sel, VECS[i].fm, VECS[i].fa, VECS[i].fa2, 1'b0, ns, nc);
      check($sformatf("R3 R8 stop-mode length vec %0d", i), ns, int'(VECS[i].n_stop));
      check($sformatf("R2 R3 R8 full length vec %0d", i), nc, int'(VECS[i].n_cont));
      check($sformatf("R6 R7 fail vec %0d", i), int'(fail), int'(VECS[i].f));
      check($sformatf("R7 R8 fail cont vec %0d", i), int'(fail_c), int'(VECS[i].f));
      if (VECS[i].f) begin
        check($sformatf("R4 R7 fail_addr vec %0d", i), int'(fail_addr), int'(VECS[i].faddr));
        check($sformatf("R7 fail_elem vec %0d", i), int'(fail_elem), int'(VECS[i].felem));
        check($sformatf("R7 first kept fail_addr cont vec %0d", i), int'(fail_addr_c), int'(VECS[i].faddr));
        check($sformatf("R7 first kept fail_elem cont vec %0d", i), int'(fail_elem_c), int'(VECS[i].felem));
      end
      @(posedge clk); #1;
      check($sformatf("R3 done one cycle vec %0d", i), int'(done), 0);
    end

    // R1: start pulse in the middle of March C- is ignored
    run(3'd4, 2'd0, 4'd0, 4'd0, 1'b1, ns, nc);
    check("R1 mid-test start ignored", ns, 161);

    // R9: failure record holds while idle
    run(3'd1, 2'd2, 4'd3, 4'd0, 1'b0, ns, nc);
    repeat (6) @(posedge clk);
    #1;
    check("R9 fail held", int'(fail), 1);
    check("R9 fail_addr held", int'(fail_addr), 3);
    check("R9 fail_elem held", int'(fail_elem), 1);
    run(3'd0, 2'd0, 4'd0, 4'd0, 1'b0, ns, nc);
    check("R9 clean rerun", int'(fail), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule